// File: doc/BRIEF.md
# Oversampled Stereo Bitstream Modulator

This block converts a stereo stream of signed PCM words into two one-bit pulse-density streams, one for each channel. Each channel passes through three stages in a fixed order. A linear interpolator first produces four values for every input sample. A dither stage then adds a constant offset and, when enabled, a small pseudo-random term. A second-order error-feedback sigma-delta loop finally produces one output bit on every clock cycle. Averaged over a long window, the fraction of ones on a channel tracks the value fed into its shaper.

The modulator runs at N times the sample rate, and one modulator cycle is one clock cycle. N is taken from a table indexed by the clock mode and the sample-rate code, so that the modulator clock stays near 12 MHz. Each interpolated value is held for N/4 cycles, and `quarterTick` marks the start of each new hold interval. A new PCM word enters the pipeline only on a cycle where `sampleStrobe` is high. The mode inputs are meant to be set while the block is idle. If any of them changes while the block is running, all filter and loop state is cleared.

Top module: `pdmStereoModulator`

## Requirements
- R1: With `extClockMode`=1, `quarterTick` is a one-cycle pulse that repeats every N/4 clock cycles. N is 384 when `sel384`=1 and 256 when `sel384`=0, and `rateCode` has no effect in this mode.
- R2: With `extClockMode`=0, N is selected by `rateCode` as follows: codes 0 and 1 (48 and 44.1 kHz) give 256, code 2 (32 kHz) gives 384, codes 3 and 4 (24 and 22.05 kHz) give 512, code 5 (16 kHz) gives 768, and the unused codes 6 and 7 give 256.
- R3: Each channel has its own independent shaper, whose input x is held constant between `quarterTick` pulses. For a steady x, the number of ones over 4096 cycles is (x+32768)/16, within ±8.
- R4: The signed `dcOffset` is added to the shaper input of both channels, so a steady PCM value p gives density (p+dcOffset+32768)/16 per 4096 cycles.
- R5: When `acDitherEn`=1, a signed pseudo-random value of DITHER_BITS width (±32 by default), drawn from a 16-bit LFSR, is added at each 4×fs step. This changes the bit pattern but keeps the density within ±10 of the undithered value. When `acDitherEn`=0, the output is deterministic.
- R6: A PCM word is captured only on cycles where `sampleStrobe`=1. Changes on `pcmLeft` and `pcmRight` at other times have no effect on the output.
- R7: A change of `extClockMode`, `rateCode` or `sel384` after the first cycle out of reset clears the counters, the interpolator, the dither source and both integrators. The bit sequence that follows is then identical to the one that follows a reset with the same inputs.
- R8: While `rstN`=0, `bitLeft`, `bitRight` and `quarterTick` are 0.
- R9: The integrators saturate and never wrap. A full-scale negative input gives a density of 0 (within ±8), and a full-scale positive input gives a density of 4095 (within ±8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock, N×fs |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleStrobe | input | 1 | Capture enable for the PCM words |
| pcmLeft | input | PCM_W | Left sample, signed |
| pcmRight | input | PCM_W | Right sample, signed |
| dcOffset | input | PCM_W | Signed offset added to both shaper inputs |
| acDitherEn | input | 1 | Enables pseudo-random dither |
| extClockMode | input | 1 | 1 selects the external-clock ratio table |
| rateCode | input | 3 | Sample-rate code used in the internal modes |
| sel384 | input | 1 | Selects the 384 ratio in external-clock mode |
| bitLeft | output | 1 | Left density bit |
| bitRight | output | 1 | Right density bit |
| quarterTick | output | 1 | Pulse at each 4×fs step |

## Verification
The bench measures the `quarterTick` period for every row of the ratio table, including the unused rate codes and a row where `rateCode` must be ignored. A wrong table entry would show up as a wrong period. It counts ones at full-scale inputs, where a loop that wraps instead of saturating would collapse its density. It holds `sampleStrobe` low while changing the PCM words, to catch a design that samples the inputs continuously. It compares the bit sequence after a mid-run mode change with the sequence after a reset. A design that left any integrator or counter uncleared would diverge in that comparison. Enabling dither must change the pattern while keeping the mean, which catches both a dead LFSR and a dither term with a DC bias.

// File: rtl/pdmModPkg.sv
package pdmModPkg;
  typedef struct packed {
    logic               clear;
    logic               step;
    logic               wrap;
    logic [1:0]         phase;
    logic signed [15:0] dither;
  } ctlStrobes_t;
endpackage

// File: rtl/pdmModControl.sv
module pdmModControl
  import pdmModPkg::*;
#(
  parameter int DITHER_BITS = 6,
  parameter int MAX_QUARTER = 192
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        extClockMode,
  input  logic [2:0]  rateCode,
  input  logic        sel384,
  input  logic        acDitherEn,
  output ctlStrobes_t ctl,
  output logic        quarterTick
);
  localparam int CNT_W = $clog2(MAX_QUARTER);
  localparam logic [15:0] LFSR_SEED = 16'hACE1;

  logic [4:0]       modeNow, modeReg;
  logic             armed;
  logic [CNT_W-1:0] subCnt, lastCnt;
  logic [1:0]       phase;
  logic [15:0]      lfsr;
  logic             clearS, stepS, lfsrFb;

  assign modeNow = {extClockMode, rateCode, sel384};

  // N/4 - 1 for the selected mode
  always_comb begin
    if (extClockMode) begin
      lastCnt = sel384 ? CNT_W'(95) : CNT_W'(63);
    end else begin
      case (rateCode)
        3'd2:       lastCnt = CNT_W'(95);
        3'd3, 3'd4: lastCnt = CNT_W'(127);
        3'd5:       lastCnt = CNT_W'(191);
        default:    lastCnt = CNT_W'(63);
      endcase
    end
  end

  assign clearS = armed && (modeNow != modeReg);
  assign stepS  = !clearS && (subCnt == lastCnt);
  assign lfsrFb = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      armed   <= 1'b0;
      subCnt  <= '0;
      phase   <= '0;
      lfsr    <= LFSR_SEED;
    end else begin
      modeReg <= modeNow;
      armed   <= 1'b1;
      if (clearS) begin
        subCnt <= '0;
        phase  <= '0;
        lfsr   <= LFSR_SEED;
      end else if (stepS) begin
        subCnt <= '0;
        phase  <= phase + 2'd1;
        lfsr   <= {lfsr[14:0], lfsrFb};
      end else begin
        subCnt <= subCnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    ctl.clear  = clearS;
    ctl.step   = stepS;
    ctl.wrap   = stepS && (phase == 2'd3);
    ctl.phase  = phase;
    ctl.dither = acDitherEn ? 16'(signed'(lfsr[DITHER_BITS-1:0])) : 16'sd0;
  end

  assign quarterTick = stepS;

  // R1: steps are never back to back
  assert_step_gap_R1: assert property (@(posedge clk) disable iff (!rstN)
    stepS |=> !stepS);
  // R7: a mode change restarts the timing chain
  assert_clear_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    clearS |=> (subCnt == '0 && phase == 2'd0));
  // R3: the interpolation phase moves only on a step
  assert_phase_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!stepS && !clearS) |=> $stable(phase));
endmodule

// File: rtl/pdmChannel.sv
module pdmChannel
  import pdmModPkg::*;
#(
  parameter int PCM_W = 16,
  parameter int GUARD = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobes_t             ctl,
  input  logic                    sampleStrobe,
  input  logic signed [PCM_W-1:0] pcmIn,
  input  logic signed [PCM_W-1:0] dcOffset,
  output logic                    bitOut
);
  localparam int HW = PCM_W + 2;
  localparam int IW = PCM_W + GUARD;
  localparam logic signed [IW-1:0] FULL  = {{(IW-PCM_W){1'b0}}, 1'b1, {(PCM_W-1){1'b0}}};
  localparam logic signed [IW-1:0] MAX_S = {1'b0, {(IW-1){1'b1}}};
  localparam logic signed [IW-1:0] MIN_S = {1'b1, {(IW-1){1'b0}}};
  localparam logic signed [IW-1:0] QUART = {3'b000, {(IW-3){1'b1}}};

  logic signed [PCM_W-1:0] latchS, prevS, curS;
  logic signed [HW-1:0]    held, heldNext;
  logic signed [IW-1:0]    i1, i2, i1n, i2n, fb;
  logic signed [3:0]       kS;
  logic signed [PCM_W:0]   diff, interpV;
  logic signed [PCM_W+4:0] prod;
  logic signed [IW:0]      sum1, sum2;

  function automatic logic signed [IW-1:0] clampSum(input logic signed [IW:0] s);
    if (s[IW] != s[IW-1]) return s[IW] ? MIN_S : MAX_S;
    return s[IW-1:0];
  endfunction

  // interpolation: prev + (cur - prev) * k / 4, k = 1..4
  assign kS       = signed'({2'b00, ctl.phase}) + 4'sd1;
  assign diff     = (PCM_W+1)'(curS) - (PCM_W+1)'(prevS);
  assign prod     = (PCM_W+5)'(diff) * (PCM_W+5)'(kS);
  assign interpV  = (PCM_W+1)'(prevS) + (PCM_W+1)'(prod >>> 2);
  assign heldNext = HW'(interpV) + HW'(dcOffset) + HW'(ctl.dither);

  // second-order error-feedback loop
  assign fb   = i2[IW-1] ? -FULL : FULL;
  assign sum1 = (IW+1)'(i1) + (IW+1)'(held) - (IW+1)'(fb);
  assign i1n  = clampSum(sum1);
  assign sum2 = (IW+1)'(i2) + (IW+1)'(i1n) - (IW+1)'(fb);
  assign i2n  = clampSum(sum2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             latchS <= '0;
    else if (sampleStrobe) latchS <= pcmIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevS <= '0; curS <= '0; held <= '0;
      i1 <= '0; i2 <= '0; bitOut <= 1'b0;
    end else if (ctl.clear) begin
      prevS <= '0; curS <= '0; held <= '0;
      i1 <= '0; i2 <= '0; bitOut <= 1'b0;
    end else begin
      i1     <= i1n;
      i2     <= i2n;
      bitOut <= !i2[IW-1];
      if (ctl.step) held <= heldNext;
      if (ctl.wrap) begin
        prevS <= curS;
        curS  <= latchS;
      end
    end
  end

  // R3: shaper input is held between steps
  assert_held_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.step && !ctl.clear) |=> $stable(held));
  // R7: a clear empties the loop
  assert_clear_state_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> (i1 == '0 && i2 == '0 && !bitOut));
  // R9: integrators saturate rather than wrap
  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rstN)
    (i1 > QUART) |=> !(i1 < -QUART));
  // R6: captured word changes only under the strobe
  assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStrobe |=> $stable(latchS));
endmodule

// File: rtl/pdmStereoModulator.sv
module pdmStereoModulator
  import pdmModPkg::*;
#(
  parameter int PCM_W       = 16,
  parameter int GUARD       = 6,
  parameter int DITHER_BITS = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sampleStrobe,
  input  logic signed [PCM_W-1:0] pcmLeft,
  input  logic signed [PCM_W-1:0] pcmRight,
  input  logic signed [PCM_W-1:0] dcOffset,
  input  logic                    acDitherEn,
  input  logic                    extClockMode,
  input  logic [2:0]              rateCode,
  input  logic                    sel384,
  output logic                    bitLeft,
  output logic                    bitRight,
  output logic                    quarterTick
);
  localparam int CHANNELS = 2;

  ctlStrobes_t             ctl;
  logic signed [PCM_W-1:0] pcmArr [CHANNELS];
  logic                    bitArr [CHANNELS];

  assign pcmArr[0] = pcmLeft;
  assign pcmArr[1] = pcmRight;
  assign bitLeft   = bitArr[0];
  assign bitRight  = bitArr[1];

  pdmModControl #(.DITHER_BITS(DITHER_BITS)) ctrl_i (
    .clk(clk), .rstN(rstN), .extClockMode(extClockMode), .rateCode(rateCode),
    .sel384(sel384), .acDitherEn(acDitherEn), .ctl(ctl), .quarterTick(quarterTick)
  );

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    pdmChannel #(.PCM_W(PCM_W), .GUARD(GUARD)) chan_i (
      .clk(clk), .rstN(rstN), .ctl(ctl), .sampleStrobe(sampleStrobe),
      .pcmIn(pcmArr[c]), .dcOffset(dcOffset), .bitOut(bitArr[c])
    );
  end
endmodule

// File: tb/pdmStereoModulator_tb_top.sv
module pdmStereoModulator_tb_top;
  localparam int REC = 1024;
  localparam int WIN = 4096;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleStrobe = 1'b1;
  logic signed [15:0] pcmLeft = '0, pcmRight = '0, dcOffset = '0;
  logic acDitherEn = 1'b0, extClockMode = 1'b0, sel384 = 1'b0;
  logic [2:0] rateCode = '0;
  logic bitLeft, bitRight, quarterTick;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  pdmStereoModulator dut_i (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .pcmLeft(pcmLeft),
    .pcmRight(pcmRight), .dcOffset(dcOffset), .acDitherEn(acDitherEn),
    .extClockMode(extClockMode), .rateCode(rateCode), .sel384(sel384),
    .bitLeft(bitLeft), .bitRight(bitRight), .quarterTick(quarterTick)
  );

  // {ext, rate[2:0], sel384, left[15:0], right[15:0], N[9:0]}
  localparam logic [46:0] VECS [10] = '{
    {1'b1, 3'd0, 1'b0, 16'h0000, 16'h0000, 10'd256},
    {1'b1, 3'd0, 1'b1, 16'h4000, 16'hC000, 10'd384},
    {1'b0, 3'd0, 1'b0, 16'h2000, 16'hE000, 10'd256},
    {1'b0, 3'd1, 1'b0, 16'hA000, 16'h6000, 10'd256},
    {1'b0, 3'd2, 1'b0, 16'h0FA0, 16'hFF9C, 10'd384},
    {1'b0, 3'd3, 1'b0, 16'h4E20, 16'hB1E0, 10'd512},
    {1'b0, 3'd4, 1'b0, 16'hFFFF, 16'h0001, 10'd512},
    {1'b0, 3'd5, 1'b0, 16'h3039, 16'h8AD0, 10'd768},
    {1'b0, 3'd6, 1'b1, 16'h0064, 16'h00C8, 10'd256},
    {1'b1, 3'd5, 1'b1, 16'h0BB8, 16'hF448, 10'd384}
  };

  task automatic checkNear(string req, string what, int act, int exp, int tol);
    nChecks++;
    if (act < exp - tol || act > exp + tol) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d (tol %0d)", req, what, act, exp, tol);
    end
  endtask

  function automatic int expOnes(int x);
    return (x + 32768) * WIN / 65536;
  endfunction

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measurePeriod(output int p);
    int guard = 0;
    p = 0;
    while (!quarterTick && guard < 2000) begin @(negedge clk); guard++; end
    @(negedge clk); p = 1;
    while (!quarterTick && p < 2000) begin @(negedge clk); p++; end
  endtask

  task automatic measureDensity(output int l, output int r);
    l = 0; r = 0;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      l += int'(bitLeft); r += int'(bitRight);
    end
  endtask

  task automatic recordBits(output bit [REC-1:0] l, output bit [REC-1:0] r);
    for (int i = 0; i < REC; i++) begin
      if (i != 0) @(negedge clk);
      l[i] = bitLeft; r[i] = bitRight;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL R3 watchdog: actual 200000 cycles expected completion earlier");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int p, dl, dr, dl0, dr0;
    bit [REC-1:0] refL, refR, gotL, gotR;

    // R8: reset state
    settle(3);
    checkNear("R8", "bitLeft in reset", int'(bitLeft), 0, 0);
    checkNear("R8", "bitRight in reset", int'(bitRight), 0, 0);
    checkNear("R8", "quarterTick in reset", int'(quarterTick), 0, 0);
    rstN = 1'b1;

    // R1 R2 R3: ratio table and density
    foreach (VECS[v]) begin
      @(negedge clk);
      extClockMode = VECS[v][46];
      rateCode     = VECS[v][45:43];
      sel384       = VECS[v][42];
      pcmLeft      = VECS[v][41:26];
      pcmRight     = VECS[v][25:10];
      settle(2000);
      measurePeriod(p);
      checkNear(VECS[v][46] ? "R1" : "R2", "tick period", p, int'(VECS[v][9:0]) / 4, 0);
      measureDensity(dl, dr);
      checkNear("R3", "left density", dl, expOnes(int'(pcmLeft)), 8);
      checkNear("R3", "right density", dr, expOnes(int'(pcmRight)), 8);
    end

    // R4: DC offset
    @(negedge clk);
    extClockMode = 1'b0; rateCode = 3'd0; sel384 = 1'b0;
    pcmLeft = 16'sd0; pcmRight = 16'sd1000; dcOffset = 16'sd8192;
    settle(1000);
    measureDensity(dl, dr);
    checkNear("R4", "left with offset", dl, expOnes(8192), 8);
    checkNear("R4", "right with offset", dr, expOnes(9192), 8);
    dcOffset = -16'sd4096;
    settle(1000);
    measureDensity(dl, dr);
    checkNear("R4", "right with negative offset", dr, expOnes(1000 - 4096), 8);
    dcOffset = 16'sd0;

    // R9: full scale, saturating loop
    pcmLeft = -16'sd32768; pcmRight = 16'sd32767;
    settle(1000);
    measureDensity(dl, dr);
    checkNear("R9", "negative full scale", dl, 0, 8);
    checkNear("R9", "positive full scale", dr, 4095, 8);

    // R6: inputs ignored without strobe
    pcmLeft = 16'sd16384; pcmRight = -16'sd16384;
    settle(1000);
    sampleStrobe = 1'b0;
    pcmLeft = -16'sd16384; pcmRight = 16'sd16384;
    settle(1000);
    measureDensity(dl, dr);
    checkNear("R6", "left holds old word", dl, expOnes(16384), 8);
    checkNear("R6", "right holds old word", dr, expOnes(-16384), 8);
    sampleStrobe = 1'b1;
    @(negedge clk);
    sampleStrobe = 1'b0;
    settle(1000);
    measureDensity(dl, dr);
    checkNear("R6", "left takes strobed word", dl, expOnes(-16384), 8);
    sampleStrobe = 1'b1;

    // R7: mode change matches reset
    @(negedge clk);
    pcmLeft = 16'sd5000; pcmRight = -16'sd12000;
    rstN = 1'b0;
    settle(3);
    rstN = 1'b1;
    recordBits(refL, refR);
    @(negedge clk);
    rateCode = 3'd3;
    settle(500);
    rateCode = 3'd0;
    @(negedge clk);
    recordBits(gotL, gotR);
    checkNear("R7", "left bits differing after mode change", $countones(refL ^ gotL), 0, 0);
    checkNear("R7", "right bits differing after mode change", $countones(refR ^ gotR), 0, 0);

    // R5: dither changes pattern, keeps mean
    @(negedge clk);
    acDitherEn = 1'b1;
    rstN = 1'b0;
    settle(3);
    rstN = 1'b1;
    recordBits(gotL, gotR);
    nChecks++;
    if ($countones(refL ^ gotL) == 0) begin
      nFails++;
      $display("FAIL R5 dither pattern: actual 0 differing bits expected nonzero");
    end
    pcmLeft = 16'sd2000; pcmRight = -16'sd3000;
    settle(1000);
    measureDensity(dl0, dr0);
    checkNear("R5", "left density with dither", dl0, expOnes(2000), 10);
    checkNear("R5", "right density with dither", dr0, expOnes(-3000), 10);
    acDitherEn = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule